// File: doc/BRIEF.md
# Speculative DFE Slicer with Pattern-Gated Timing Detector

This block resolves received bits for a one-tap decision feedback equalizer built in loop-unrolled form. For every unit interval two comparators present their results: one compared against a positive offset threshold and one against a negative offset threshold. The block keeps the bit it decided last. It takes the positive-threshold result when that bit was 1 and the negative-threshold result when it was 0.

The same two comparator results also give clock-recovery timing, so no edge sampler is needed. The block tracks its three most recent decisions. When they read 1,0,0 or 0,1,1 (oldest first), it compares the comparator pair of the newest bit and emits a one-cycle early or late strobe. A saturating signed phase code counts down on early and up on late. It is exposed for a phase interpolator outside the block. A synchronous clear empties the decision history and zeroes the phase code.

Top module: `dfe_spec_pd`

## Requirements
- R1: When the previous decision is 1, the new decision equals `cmp_hi`.
- R2: When the previous decision is 0, the new decision equals `cmp_lo`.
- R3: The first decision after reset or clear uses a previous decision of 0.
- R4: `bit_valid` is high exactly one clock after an accepted input (`in_valid` high, `clr` low), and `bit_out` carries that decision in the same cycle.
- R5: `early` and `late` pulse only for the decision that completes a 1,0,0 or 0,1,1 window (oldest first), and only once at least three decisions exist since reset or clear. A strobe is high in the same cycle as `bit_valid` for that decision.
- R6: For window 1,0,0, `early` pulses if `cmp_hi` is 0 and `late` pulses if `cmp_hi` is 1.
- R7: For window 0,1,1, `early` pulses if `cmp_lo` is 1 and `late` pulses if `cmp_lo` is 0.
- R8: `early` and `late` are never high together, and neither is high without `bit_valid`.
- R9: `phase_code` (two's complement) decreases by 1 with each `early` and increases by 1 with each `late`, in the same cycle as the strobe. It holds otherwise.
- R10: `phase_code` saturates at -128 and +127 and never wraps.
- R11: With `clr` high, the next cycle shows `phase_code` = 0, no `bit_valid` and no strobes, and the decision history is empty.
- R12: Cycles with `in_valid` low change neither the history nor the previous decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of history and phase code |
| in_valid | input | 1 | Comparator pair valid for this unit interval |
| cmp_hi | input | 1 | Result of the positive-offset comparator |
| cmp_lo | input | 1 | Result of the negative-offset comparator |
| bit_valid | output | 1 | Decision valid strobe |
| bit_out | output | 1 | Decided bit |
| early | output | 1 | Early timing vote strobe |
| late | output | 1 | Late timing vote strobe |
| phase_code | output | 8 | Signed saturating phase accumulator |

## Verification
The case hardest to reach from the ports is the pair of phase-code limits. Reaching either one needs well over a hundred votes of the same sign, and each vote needs a three-decision window shaped by earlier decisions through the feedback. The stimulus repeats a comparator triplet that decides 1,0,0 and ends in a chosen vote. It runs enough triplets to drive the code to -128 and then to +127, and checks that it stays pinned at each limit. A second subtle point is the history after a clear. The bench clears straight after a completed window and shows that the decisions that follow cast no vote until three new ones exist.

// File: rtl/dfe_spec_pd.sv
module dfe_spec_pd #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  input  logic          cmp_hi,
  input  logic          cmp_lo,
  output logic          bit_valid,
  output logic          bit_out,
  output logic          early,
  output logic          late,
  output logic [PW-1:0] phase_code
);
  localparam logic signed [PW-1:0] PMAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic signed [PW-1:0] PMIN = {1'b1, {(PW-1){1'b0}}};

  logic [1:0] hist;
  logic [1:0] fill;
  logic signed [PW-1:0] phase_q;

  wire dec    = hist[0] ? cmp_hi : cmp_lo;
  wire [2:0] win = {hist, dec};
  wire armed  = in_valid && !clr && (fill == 2'd2);
  wire p100   = armed && (win == 3'b100);
  wire p011   = armed && (win == 3'b011);
  wire v_early = (p100 && !cmp_hi) || (p011 && cmp_lo);
  wire v_late  = (p100 && cmp_hi) || (p011 && !cmp_lo);

  assign phase_code = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      fill      <= '0;
      phase_q   <= '0;
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
      early     <= 1'b0;
      late      <= 1'b0;
    end else if (clr) begin
      hist      <= '0;
      fill      <= '0;
      phase_q   <= '0;
      bit_valid <= 1'b0;
      early     <= 1'b0;
      late      <= 1'b0;
    end else begin
      bit_valid <= in_valid;
      early     <= v_early;
      late      <= v_late;
      if (in_valid) begin
        bit_out <= dec;
        hist    <= {hist[0], dec};
        if (fill != 2'd2) fill <= fill + 2'd1;
      end
      if (v_early && phase_q != PMIN) phase_q <= phase_q - PW'(1);
      else if (v_late && phase_q != PMAX) phase_q <= phase_q + PW'(1);
    end
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(early && late));

  // R8
  strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (early || late) |-> bit_valid);

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid == $past(in_valid && !clr));

  // R9
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (early && $past(phase_q) != PMIN) |-> phase_q == $past(phase_q) - PW'(1));

  // R9
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (late && $past(phase_q) != PMAX) |-> phase_q == $past(phase_q) + PW'(1));

  // R10
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (early && $past(phase_q) == PMIN) |-> phase_q == PMIN);

  // R10
  ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (late && $past(phase_q) == PMAX) |-> phase_q == PMAX);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!early && !late && !$past(clr)) |-> $stable(phase_q));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (phase_q == '0 && !bit_valid && !early && !late));
endmodule

// File: tb/sim_dfe_spec_pd.sv
module sim_dfe_spec_pd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, in_valid = 1'b0, cmp_hi = 1'b0, cmp_lo = 1'b0;
  logic bit_valid, bit_out, early, late;
  logic [7:0] phase_code;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dfe_spec_pd u0 (.clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .bit_valid(bit_valid), .bit_out(bit_out),
    .early(early), .late(late), .phase_code(phase_code));

  // {valid, hi, lo, exp_valid, exp_bit, exp_early, exp_late, exp_phase}
  localparam logic [14:0] VEC [12] = '{
    {7'b1111100, 8'h00},
    {7'b1001000, 8'h00},
    {7'b1001010, 8'hFF},
    {7'b1111100, 8'hFF},
    {7'b1101101, 8'h00},
    {7'b0000000, 8'h00},
    {7'b1111100, 8'h00},
    {7'b1011000, 8'h00},
    {7'b1101001, 8'h01},
    {7'b1111100, 8'h01},
    {7'b1111110, 8'h00},
    {7'b1001000, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic hi, input logic lo);
    in_valid = v; cmp_hi = hi; cmp_lo = lo;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset bit_valid", bit_valid, 0);
    chk("R11 reset strobes", early | late, 0);
    chk("R11 reset phase", phase_code, 0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][14], VEC[i][13], VEC[i][12]);
      chk($sformatf("R4 row%0d bit_valid", i), bit_valid, VEC[i][11]);
      if (VEC[i][11]) chk($sformatf("R1,R2,R3,R12 row%0d bit", i), bit_out, VEC[i][10]);
      chk($sformatf("R5,R6,R7 row%0d early", i), early, VEC[i][9]);
      chk($sformatf("R5,R6,R7 row%0d late", i), late, VEC[i][8]);
      chk($sformatf("R9 row%0d phase", i), phase_code, VEC[i][7:0]);
    end

    // floor: triplets deciding 1,0,0 with early vote
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    for (int k = 0; k < 130; k++) begin
      step(1, 1, 1); step(1, 0, 0); step(1, 0, 0);
    end
    chk("R10 floor", phase_code, 8'h80);
    step(1, 1, 1); step(1, 0, 0); step(1, 0, 0);
    chk("R10 floor early seen", early, 1);
    chk("R10 floor held", phase_code, 8'h80);

    // ceiling: triplets deciding 1,0,0 with late vote
    for (int k = 0; k < 260; k++) begin
      step(1, 1, 1); step(1, 0, 0); step(1, 1, 0);
    end
    chk("R10 ceiling", phase_code, 8'h7F);
    step(1, 1, 1); step(1, 0, 0); step(1, 1, 0);
    chk("R10 ceiling late seen", late, 1);
    chk("R10 ceiling held", phase_code, 8'h7F);

    // clear empties history and zeroes phase
    clr = 1'b1; in_valid = 1'b1; @(negedge clk); clr = 1'b0; in_valid = 1'b0;
    chk("R11 clear phase", phase_code, 0);
    chk("R11 clear bit_valid", bit_valid, 0);
    step(1, 1, 0);
    chk("R3 first bit after clear", bit_out, 0);
    chk("R11 no vote after clear", early | late, 0);
    step(1, 1, 0);
    chk("R11 no vote second", early | late, 0);
    step(1, 1, 1);
    chk("R5 window 001 no vote", early | late, 0);
    step(1, 1, 0);
    chk("R1 bit follows hi", bit_out, 1);
    chk("R7 window 011 late", late, 1);
    chk("R9 phase after late", phase_code, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule